// File: doc/BRIEF.md
# Radio Operating Mode Controller

This block decides, clock by clock, which operating mode a packet radio core is in: power down, two idle standby levels, receive, transmit, and one settle state ahead of receive and one ahead of transmit, in which the synthesizer locks. It reads the power-on and receive-role configuration bits, an asynchronous chip-enable pin, the TX FIFO empty flag, the RX FIFO full flag, and two strobes from the packet engine: valid packet received and packet transmission done. From these it drives the mode code, the synthesizer (PLL) enable, a TX FIFO pop, an RX FIFO push or drop, and a transmit timeout flag.

All microsecond delays come from a ticks-per-microsecond parameter. The settle delay, the minimum chip-enable pulse and the transmit watchdog are each turned into cycle counts at elaboration. Chip-enable is synchronized with two flip-flops. A short pulse that is long enough starts a single transmission. Holding chip-enable high keeps the transmitter draining the FIFO, and with the FIFO empty it parks in a warm standby. From there a newly loaded packet goes straight into the settle delay.

Top module: `radio_mode_ctrl`

## Requirements
- R1: After reset, and one cycle after power_on_i is sampled low in any state, mode_o is 0 (power down).
- R2: mode_o uses the code 0 power down, 1 standby-I, 2 standby-II, 3 RX settle, 4 RX, 5 TX settle, 6 TX. pll_en_o is low in codes 0 and 1 and high in all the others.
- R3: With power_on_i high and chip-enable low, power down moves to standby-I (1) on the next cycle and stays there.
- R4: In standby, synchronized chip-enable high with rx_role_i high enters RX settle (3). RX settle lasts exactly SETTLE cycles (TICKS_PER_US*SETTLE_US) and is followed by RX (4).
- R5: TX starts from standby-I only when rx_role_i is low, the TX FIFO is not empty and synchronized chip-enable has stayed high for at least CE_MIN cycles (TICKS_PER_US*CE_MIN_US). Shorter pulses leave the mode at 1. TX settle (5) lasts SETTLE cycles, and tx_pop_o is high during the first TX (6) cycle only.
- R6: A packet-done strobe in TX with chip-enable low returns to standby-I.
- R7: A packet-done strobe in TX with chip-enable high and TX FIFO not empty stays in TX and raises tx_pop_o in the next cycle.
- R8: A packet-done strobe in TX with chip-enable high and TX FIFO empty enters standby-II (2). In standby-II, a non-empty TX FIFO moves to TX settle on the next cycle.
- R9: In RX, rx_push_o equals pkt_valid_i AND NOT rx_full_i and rx_drop_o equals pkt_valid_i AND rx_full_i, in the same cycle. Both are low outside RX.
- R10: RX is held while chip-enable and rx_role_i stay high, whatever the packet strobes do. Chip-enable low leaves to standby-I.
- R11: If TX runs TX_MAX cycles (TICKS_PER_US*TX_MAX_US) after its last pop without a packet-done strobe, tx_timeout_o is high in that last TX cycle and the mode then returns to standby-I.
- R12: In RX with chip-enable high, rx_role_i going low with a non-empty TX FIFO moves to TX settle, never directly to TX.
- R13: Once TX settle has begun, dropping chip-enable does not abort it, and TX follows after the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| power_on_i | input | 1 | Configuration: core powered |
| rx_role_i | input | 1 | Configuration: 1 receive role, 0 transmit role |
| chip_en_i | input | 1 | Asynchronous chip-enable pin |
| tx_empty_i | input | 1 | TX FIFO holds no packet |
| rx_full_i | input | 1 | RX FIFO has no free slot |
| pkt_valid_i | input | 1 | Strobe: received packet passed address and CRC |
| pkt_done_i | input | 1 | Strobe: current transmit packet finished |
| mode_o | output | 3 | Current mode code (R2) |
| pll_en_o | output | 1 | Synthesizer enable |
| tx_pop_o | output | 1 | Take one packet from the TX FIFO |
| rx_push_o | output | 1 | Write received payload to the RX FIFO |
| rx_drop_o | output | 1 | Received packet discarded, RX FIFO full |
| tx_timeout_o | output | 1 | Transmit watchdog expired, forced exit |

## Verification
The hardest case to reach is the boundary of chip-enable pulse qualification. Behind the two-stage synchronizer, a pulse one cycle shorter than the minimum must leave the controller idle, and a pulse exactly at the minimum must start transmission. The bench sweeps pulse widths from one cycle up past the threshold and checks, for each width, whether TX settle appears. It also drives a transmit stay into the watchdog limit by withholding packet-done, and it walks the standby-II reload and the receive-to-transmit switch from inside RX.

// File: rtl/radio_mode_pkg.sv
package radio_mode_pkg;
  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_STBY1  = 3'd1,
    M_STBY2  = 3'd2,
    M_RX_SET = 3'd3,
    M_RX     = 3'd4,
    M_TX_SET = 3'd5,
    M_TX     = 3'd6
  } mode_e;
endpackage

// File: rtl/rmc_ce_sync.sv
module rmc_ce_sync #(
  parameter int CE_CYC = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  output logic ce_lvl_o,
  output logic ce_qual_o
);
  localparam int CW = $clog2(CE_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(CE_CYC);

  logic          meta_q, sync_q;
  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= ce_i;
      sync_q <= meta_q;
    end
  end

  // saturating width counter, restarted by every low sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hi_cnt_q <= '0;
    else if (!sync_q)        hi_cnt_q <= '0;
    else if (hi_cnt_q != FULL) hi_cnt_q <= hi_cnt_q + CW'(1);
  end

  assign ce_lvl_o  = sync_q;
  assign ce_qual_o = (hi_cnt_q == FULL);

  assert_qual_hist_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_qual_o) |-> $past(ce_lvl_o));
endmodule

// File: rtl/rmc_tick_timer.sv
module rmc_tick_timer #(
  parameter int LIMIT = 2080
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (en_i && cnt_q != LAST)  cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == LAST);

  assert_cnt_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_clear_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && LIMIT > 1) |=> !done_o);
endmodule

// File: rtl/rmc_mode_fsm.sv
module rmc_mode_fsm
  import radio_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  power_on_i,
  input  logic  rx_role_i,
  input  logic  ce_lvl_i,
  input  logic  ce_qual_i,
  input  logic  tx_empty_i,
  input  logic  rx_full_i,
  input  logic  pkt_valid_i,
  input  logic  pkt_done_i,
  input  logic  settle_done_i,
  input  logic  wd_done_i,
  output mode_e state_o,
  output logic  settle_clr_o,
  output logic  settle_en_o,
  output logic  wd_clr_o,
  output logic  wd_en_o,
  output logic  pll_en_o,
  output logic  tx_pop_o,
  output logic  rx_push_o,
  output logic  rx_drop_o,
  output logic  tx_timeout_o
);
  mode_e state_q, state_d;
  logic  pop_d, pop_q, timeout_d;

  always_comb begin
    state_d   = state_q;
    timeout_d = 1'b0;
    if (!power_on_i) begin
      state_d = M_OFF;
    end else begin
      unique case (state_q)
        M_OFF:   state_d = M_STBY1;
        M_STBY1: begin
          if (ce_lvl_i && rx_role_i)        state_d = M_RX_SET;
          else if (!rx_role_i && ce_qual_i) state_d = tx_empty_i ? M_STBY2 : M_TX_SET;
        end
        M_STBY2: begin
          if (!ce_lvl_i)       state_d = M_STBY1;
          else if (rx_role_i)  state_d = M_RX_SET;
          else if (!tx_empty_i) state_d = M_TX_SET;
        end
        M_RX_SET: begin
          if (!ce_lvl_i || !rx_role_i) state_d = M_STBY1;
          else if (settle_done_i)      state_d = M_RX;
        end
        M_RX: begin
          if (!ce_lvl_i)      state_d = M_STBY1;
          else if (!rx_role_i) state_d = tx_empty_i ? M_STBY2 : M_TX_SET;
        end
        // chip-enable may drop mid-settle in single-packet use
        M_TX_SET: if (settle_done_i) state_d = M_TX;
        M_TX: begin
          if (pkt_done_i) begin
            if (!ce_lvl_i)       state_d = M_STBY1;
            else if (rx_role_i)  state_d = M_RX_SET;
            else if (tx_empty_i) state_d = M_STBY2;
            else                 state_d = M_TX;
          end else if (wd_done_i) begin
            state_d   = M_STBY1;
            timeout_d = 1'b1;
          end
        end
        default: state_d = M_OFF;
      endcase
    end
  end

  // a packet leaves the FIFO on TX entry or on a back-to-back follow-on
  assign pop_d = (state_d == M_TX) && ((state_q != M_TX) || pkt_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_OFF;
      pop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pop_q   <= pop_d;
    end
  end

  assign state_o      = state_q;
  assign settle_clr_o = (state_d != state_q);
  assign settle_en_o  = (state_q == M_RX_SET) || (state_q == M_TX_SET);
  assign wd_clr_o     = pop_d;
  assign wd_en_o      = (state_q == M_TX);
  assign pll_en_o     = (state_q != M_OFF) && (state_q != M_STBY1);
  assign tx_pop_o     = pop_q;
  assign rx_push_o    = (state_q == M_RX) && pkt_valid_i && !rx_full_i;
  assign rx_drop_o    = (state_q == M_RX) && pkt_valid_i && rx_full_i;
  assign tx_timeout_o = timeout_d;

  assert_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_on_i |=> state_q == M_OFF);
  assert_rx_via_settle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_RX && $past(state_q) != M_RX) |-> $past(state_q) == M_RX_SET);
  assert_tx_via_settle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_TX && $past(state_q) != M_TX) |-> $past(state_q) == M_TX_SET);
  assert_pop_in_tx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> state_q == M_TX);
  assert_timeout_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_timeout_o && power_on_i) |=> state_q == M_STBY1);
endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
  import radio_mode_pkg::*;
#(
  parameter int TICKS_PER_US = 16,
  parameter int SETTLE_US    = 130,
  parameter int CE_MIN_US    = 10,
  parameter int TX_MAX_US    = 4000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       power_on_i,
  input  logic       rx_role_i,
  input  logic       chip_en_i,
  input  logic       tx_empty_i,
  input  logic       rx_full_i,
  input  logic       pkt_valid_i,
  input  logic       pkt_done_i,
  output logic [2:0] mode_o,
  output logic       pll_en_o,
  output logic       tx_pop_o,
  output logic       rx_push_o,
  output logic       rx_drop_o,
  output logic       tx_timeout_o
);
  localparam int SETTLE_CYC = TICKS_PER_US * SETTLE_US;
  localparam int CE_CYC     = TICKS_PER_US * CE_MIN_US;
  localparam int TX_CYC     = TICKS_PER_US * TX_MAX_US;

  logic  ce_lvl, ce_qual;
  logic  settle_clr, settle_en, settle_done;
  logic  wd_clr, wd_en, wd_done;
  mode_e state;

  rmc_ce_sync #(.CE_CYC(CE_CYC)) u_ce (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (chip_en_i),
    .ce_lvl_o  (ce_lvl),
    .ce_qual_o (ce_qual)
  );

  rmc_tick_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (settle_clr),
    .en_i    (settle_en),
    .done_o  (settle_done)
  );

  rmc_tick_timer #(.LIMIT(TX_CYC)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (wd_clr),
    .en_i    (wd_en),
    .done_o  (wd_done)
  );

  rmc_mode_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .power_on_i    (power_on_i),
    .rx_role_i     (rx_role_i),
    .ce_lvl_i      (ce_lvl),
    .ce_qual_i     (ce_qual),
    .tx_empty_i    (tx_empty_i),
    .rx_full_i     (rx_full_i),
    .pkt_valid_i   (pkt_valid_i),
    .pkt_done_i    (pkt_done_i),
    .settle_done_i (settle_done),
    .wd_done_i     (wd_done),
    .state_o       (state),
    .settle_clr_o  (settle_clr),
    .settle_en_o   (settle_en),
    .wd_clr_o      (wd_clr),
    .wd_en_o       (wd_en),
    .pll_en_o      (pll_en_o),
    .tx_pop_o      (tx_pop_o),
    .rx_push_o     (rx_push_o),
    .rx_drop_o     (rx_drop_o),
    .tx_timeout_o  (tx_timeout_o)
  );

  assign mode_o = state;
endmodule

// File: tb/sim_radio_mode_ctrl.sv
`timescale 1ns/1ps
module sim_radio_mode_ctrl;
  localparam int TPU    = 2;
  localparam int SET_US = 5;
  localparam int CE_US  = 3;
  localparam int TXM_US = 20;
  localparam int SETTLE = TPU * SET_US;
  localparam int CEMIN  = TPU * CE_US;
  localparam int TXMAX  = TPU * TXM_US;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic power_on = 1'b0, rx_role = 1'b0, chip_en = 1'b0;
  logic tx_empty = 1'b1, rx_full = 1'b0, pkt_valid = 1'b0, pkt_done = 1'b0;
  logic [2:0] mode;
  logic pll_en, tx_pop, rx_push, rx_drop, tx_timeout;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  radio_mode_ctrl #(.TICKS_PER_US(TPU), .SETTLE_US(SET_US),
                    .CE_MIN_US(CE_US), .TX_MAX_US(TXM_US)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .power_on_i(power_on), .rx_role_i(rx_role),
    .chip_en_i(chip_en), .tx_empty_i(tx_empty), .rx_full_i(rx_full),
    .pkt_valid_i(pkt_valid), .pkt_done_i(pkt_done), .mode_o(mode),
    .pll_en_o(pll_en), .tx_pop_o(tx_pop), .rx_push_o(rx_push),
    .rx_drop_o(rx_drop), .tx_timeout_o(tx_timeout)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_mode(input int m);
    for (int i = 0; i < 60 && int'(mode) != m; i++) step(1);
  endtask

  task automatic count_mode(input int m, output int n);
    n = 0;
    while (int'(mode) == m && n < 1000) begin
      n++;
      step(1);
    end
  endtask

  initial begin
    int n, to;
    bit started;
    step(3);
    chk(mode == 3'd0, "R1 mode in reset", mode, 0);
    chk(pll_en == 1'b0, "R2 pll in power down", pll_en, 0);
    rst_ni = 1'b1;
    step(3);
    chk(mode == 3'd0, "R1 power_on low holds", mode, 0);
    power_on = 1'b1;
    step(1);
    chk(mode == 3'd1, "R3 standby-I entry", mode, 1);
    step(3);
    chk(mode == 3'd1 && pll_en == 1'b0, "R3 standby-I hold, pll low", {pll_en, mode}, 1);

    // receive entry
    rx_role = 1'b1; chip_en = 1'b1;
    wait_mode(3);
    chk(pll_en == 1'b1, "R2 pll in RX settle", pll_en, 1);
    count_mode(3, n);
    chk(n == SETTLE, "R4 RX settle length", n, SETTLE);
    chk(mode == 3'd4, "R4 RX reached", mode, 4);

    // push/drop truth table
    for (int v = 0; v < 2; v++) begin
      for (int f = 0; f < 2; f++) begin
        pkt_valid = v[0]; rx_full = f[0]; pkt_done = 1'b1;
        #1;
        chk(rx_push == (v[0] & ~f[0]), "R9 push", rx_push, v & (1 - f));
        chk(rx_drop == (v[0] & f[0]), "R9 drop", rx_drop, v & f);
        step(1);
        chk(mode == 3'd4, "R10 RX held under strobes", mode, 4);
      end
    end
    pkt_valid = 1'b0; rx_full = 1'b0; pkt_done = 1'b0;

    // switch RX -> TX through settle
    tx_empty = 1'b0; rx_role = 1'b0;
    step(1);
    chk(mode == 3'd5, "R12 RX to TX settle", mode, 5);
    count_mode(5, n);
    chk(n == SETTLE, "R5 TX settle length", n, SETTLE);
    chk(mode == 3'd6, "R5 TX reached", mode, 6);
    chk(tx_pop == 1'b1, "R5 pop on TX entry", tx_pop, 1);
    step(1);
    chk(tx_pop == 1'b0, "R5 pop single cycle", tx_pop, 0);

    // back-to-back
    pkt_done = 1'b1; step(1); pkt_done = 1'b0;
    chk(mode == 3'd6, "R7 stays in TX", mode, 6);
    chk(tx_pop == 1'b1, "R7 follow-on pop", tx_pop, 1);
    step(1);
    chk(tx_pop == 1'b0, "R7 pop single cycle", tx_pop, 0);

    // drain into standby-II
    tx_empty = 1'b1; pkt_done = 1'b1; step(1); pkt_done = 1'b0;
    chk(mode == 3'd2, "R8 standby-II entry", mode, 2);
    chk(pll_en == 1'b1, "R2 pll in standby-II", pll_en, 1);
    step(3);
    chk(mode == 3'd2, "R8 standby-II hold", mode, 2);
    tx_empty = 1'b0; step(1);
    chk(mode == 3'd5, "R8 reload starts settle", mode, 5);
    chip_en = 1'b0;
    count_mode(5, n);
    chk(n == SETTLE, "R13 settle not aborted", n, SETTLE);
    chk(mode == 3'd6, "R13 TX after ce drop", mode, 6);
    pkt_done = 1'b1; step(1); pkt_done = 1'b0;
    chk(mode == 3'd1, "R6 back to standby-I", mode, 1);

    // watchdog
    chip_en = 1'b1; step(CEMIN + 2); chip_en = 1'b0;
    wait_mode(5);
    count_mode(5, n);
    chk(mode == 3'd6, "R11 TX reached", mode, 6);
    n = 0; to = 0;
    while (mode == 3'd6 && n < 1000) begin
      n++;
      if (tx_timeout) to++;
      step(1);
    end
    chk(n == TXMAX, "R11 TX stay length", n, TXMAX);
    chk(to == 1, "R11 single timeout pulse", to, 1);
    chk(mode == 3'd1, "R11 forced to standby-I", mode, 1);

    // pulse width sweep around the threshold
    for (int w = 1; w <= CEMIN + 4; w++) begin
      chip_en = 1'b1; step(w); chip_en = 1'b0;
      started = 1'b0;
      for (int k = 0; k < 12; k++) begin
        if (mode == 3'd5) started = 1'b1;
        if (!started) step(1);
      end
      chk(started == (w >= CEMIN), $sformatf("R5 pulse width %0d", w), started, w >= CEMIN);
      if (started) begin
        count_mode(5, n);
        pkt_done = 1'b1; step(1); pkt_done = 1'b0;
      end
      step(3);
      chk(mode == 3'd1, "R6 idle after sweep step", mode, 1);
    end

    // RX exit by chip-enable, then power loss from RX
    rx_role = 1'b1; chip_en = 1'b1;
    wait_mode(4);
    chk(mode == 3'd4, "R4 RX again", mode, 4);
    chip_en = 1'b0; step(4);
    chk(mode == 3'd1, "R10 ce low leaves RX", mode, 1);
    chip_en = 1'b1;
    wait_mode(4);
    power_on = 1'b0; step(1);
    chk(mode == 3'd0 && pll_en == 1'b0, "R1 power loss in RX", {pll_en, mode}, 0);

    // power loss in TX
    power_on = 1'b1; rx_role = 1'b0; chip_en = 1'b0; step(4);
    chip_en = 1'b1; step(CEMIN + 2); chip_en = 1'b0;
    wait_mode(6);
    power_on = 1'b0; step(1);
    chk(mode == 3'd0, "R1 power loss in TX", mode, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule